// File: doc/BRIEF.md
# ADC Conversion Sequencer and Status Controller

This block sequences single conversions of a successive-approximation analog-to-digital converter and keeps its status. The analog part is not modelled: a digital sample bus stands in for the converter result. A 3-bit time-select code sets the conversion length in core-clock cycles, using a doubling table that starts at 39 cycles. A start strobe begins a conversion. A busy flag tracks the conversion while it runs. When the conversion finishes, the sample is latched into a low and a high data register and a conversion-complete flag is raised.

Software reaches the block through a small register port with three addresses. A read strobe on the high data byte clears the complete flag. An input that signals entry into a low-power mode forces both flags low and abandons any conversion in flight.

The control is a three-state machine:
- `ST_IDLE`: no result is pending.
- `ST_RUN`: a conversion is running. Busy reads 1.
- `ST_HOLD`: a result is waiting. The complete flag reads 1.

The transitions are:
- `go` (`ST_IDLE`→`ST_RUN`, or `ST_HOLD`→`ST_RUN`): a start with a legal code.
- `expire` (`ST_RUN`→`ST_HOLD`): the length counter reaches zero.
- `consume` (`ST_HOLD`→`ST_IDLE`): the high data byte is read.
- `sleep` (any state→`ST_IDLE`): low-power entry. It has the highest priority.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy_o and done_o are 0, and addresses 0, 1 and 2 all read 0x00.
- R2: A conversion started with code c (0 to 5) keeps busy_o high for exactly 39·2^c clock cycles: 39, 78, 156, 312, 624 or 1248.
- R3: In the cycle busy_o falls, done_o rises. Address 2 then reads sample_i[9:2], and address 1 reads {sample_i[1:0], 6'b0}, where sample_i is the value held in the last busy cycle.
- R4: Address 0 is the status/control byte. Bit 7 is the complete flag, bit 6 is the busy flag and bits 2:0 are the time-select code.
- R5: A read strobe at address 2 clears done_o by the next cycle.
- R6: A legal start issued while a result is pending clears done_o and begins a new conversion.
- R7: A pulse on lowpwr_i clears busy_o and done_o by the next cycle. An aborted conversion leaves the data registers unchanged.
- R8: A write to the time-select code while busy_o is 1 is ignored.
- R9: A start strobe while busy_o is 1 is ignored, and the running conversion keeps its length.
- R10: Codes 6 and 7 are reserved. A start strobe while one of them is selected does not begin a conversion.
- R11: Bits 5:3 of address 0 always read 0, whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start strobe |
| lowpwr_i | input | 1 | Low-power mode entry pulse |
| sample_i | input | 10 | Digital stand-in for the converter result |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address: 0 status/control, 1 data low, 2 data high |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Conversion result pending |

## Verification
The assertions assume the following about the inputs:
- Strobes are single-cycle and synchronous to `clk`.
- `reg_rd_i` at address 2 is the only way the complete flag is consumed.
- `sample_i` is stable during the last busy cycle.

The stimulus drives every strobe for one cycle on the falling edge. It changes `sample_i` only while no conversion runs. It reaches reserved codes only through the register port, so no assertion ever sees busy with a reserved code selected.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } adc_state_e;

    localparam logic [1:0] ADDR_CSR = 2'd0;
    localparam logic [1:0] ADDR_LO  = 2'd1;
    localparam logic [1:0] ADDR_HI  = 2'd2;

endpackage

// File: rtl/adc_len_timer.sv
module adc_len_timer #(
    parameter int BASE_CYCLES = 39,
    parameter int CODE_W      = 3,
    parameter int NUM_CODES   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              run_i,
    output logic              expire_o
);
    localparam int MAX_LEN = BASE_CYCLES << (NUM_CODES - 1);
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_m1;

    // length is base shifted by the code; counter holds remaining cycles minus one
    always_comb begin
        len_m1 = (LEN_W'(BASE_CYCLES) << code_i) - LEN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_m1;
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - LEN_W'(1);
        end
    end

    assign expire_o = run_i && (cnt_q == '0);

    AST_CNT_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && cnt_q != '0) |=> (cnt_q < $past(cnt_q))); // R2

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_ok_i,
    input  logic       expire_i,
    input  logic       rd_hi_i,
    input  logic       lowpwr_i,
    output adc_state_e state_o,
    output logic       load_o,
    output logic       capture_o,
    output logic       busy_o,
    output logic       done_o
);
    adc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_ok_i) state_d = ST_RUN;          // go
            ST_RUN:  if (expire_i)   state_d = ST_HOLD;         // expire
            ST_HOLD: begin
                if (start_ok_i)   state_d = ST_RUN;             // go
                else if (rd_hi_i) state_d = ST_IDLE;            // consume
            end
            default: state_d = ST_IDLE;
        endcase
        if (lowpwr_i) state_d = ST_IDLE;                        // sleep
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy_o    = (state_q == ST_RUN);
        done_o    = (state_q == ST_HOLD);
        load_o    = start_ok_i && (state_q != ST_RUN) && !lowpwr_i;
        capture_o = (state_q == ST_RUN) && expire_i && !lowpwr_i;
    end

    assign state_o = state_q;

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R4
    AST_LOWPWR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr_i |=> (!busy_o && !done_o)); // R7
    AST_RD_HI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi_i |=> !done_o); // R5
    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_ok_i)); // R10
    AST_FALL_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !$past(lowpwr_i)) |-> done_o); // R3

endmodule

// File: rtl/adc_reg_bank.sv
module adc_reg_bank
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W  = 10,
    parameter int CODE_W    = 3,
    parameter int NUM_CODES = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_i,
    input  logic [1:0]          reg_addr_i,
    input  logic [7:0]          reg_wdata_i,
    input  logic                busy_i,
    input  logic                done_i,
    input  logic                load_i,
    input  logic                capture_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [CODE_W-1:0]   sel_o,
    output logic                sel_legal_o,
    output logic [7:0]          rdata_o
);
    localparam int ALIGN_W = 16;
    localparam int PAD_W   = 8 - 2 - CODE_W;

    logic [CODE_W-1:0]  sel_q;
    logic [7:0]         lo_q, hi_q;
    logic [ALIGN_W-1:0] aligned;
    logic               sel_we;

    assign aligned = ALIGN_W'(sample_i) << (ALIGN_W - SAMPLE_W);
    assign sel_we  = reg_wr_i && (reg_addr_i == ADDR_CSR) && !busy_i && !load_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= reg_wdata_i[CODE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (capture_i) begin
            lo_q <= aligned[7:0];
            hi_q <= aligned[15:8];
        end
    end

    always_comb begin
        unique case (reg_addr_i)
            ADDR_CSR: rdata_o = {done_i, busy_i, {PAD_W{1'b0}}, sel_q};
            ADDR_LO:  rdata_o = lo_q;
            ADDR_HI:  rdata_o = hi_q;
            default:  rdata_o = 8'h00;
        endcase
    end

    assign sel_o       = sel_q;
    assign sel_legal_o = (int'(sel_q) < NUM_CODES);

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(sel_q)); // R8
    AST_NO_RESERVED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (int'(sel_q) < NUM_CODES)); // R10
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> ($stable(lo_q) && $stable(hi_q))); // R7

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W    = 10,
    parameter int CODE_W      = 3,
    parameter int NUM_CODES   = 6,
    parameter int BASE_CYCLES = 39
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                lowpwr_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                reg_wr_i,
    input  logic                reg_rd_i,
    input  logic [1:0]          reg_addr_i,
    input  logic [7:0]          reg_wdata_i,
    output logic [7:0]          reg_rdata_o,
    output logic                busy_o,
    output logic                done_o
);
    adc_state_e        state;
    logic              load, capture, expire;
    logic              busy, done;
    logic [CODE_W-1:0] sel;
    logic              sel_legal;
    logic              start_ok;
    logic              rd_hi;

    assign start_ok = start_i && sel_legal;
    assign rd_hi    = reg_rd_i && (reg_addr_i == ADDR_HI);

    adc_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok_i (start_ok),
        .expire_i   (expire),
        .rd_hi_i    (rd_hi),
        .lowpwr_i   (lowpwr_i),
        .state_o    (state),
        .load_o     (load),
        .capture_o  (capture),
        .busy_o     (busy),
        .done_o     (done)
    );

    adc_len_timer #(
        .BASE_CYCLES (BASE_CYCLES),
        .CODE_W      (CODE_W),
        .NUM_CODES   (NUM_CODES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .code_i   (sel),
        .run_i    (state == ST_RUN),
        .expire_o (expire)
    );

    adc_reg_bank #(
        .SAMPLE_W  (SAMPLE_W),
        .CODE_W    (CODE_W),
        .NUM_CODES (NUM_CODES)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .busy_i      (busy),
        .done_i      (done),
        .load_i      (load),
        .capture_i   (capture),
        .sample_i    (sample_i),
        .sel_o       (sel),
        .sel_legal_o (sel_legal),
        .rdata_o     (reg_rdata_o)
    );

    assign busy_o = busy;
    assign done_o = done;

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !expire && !lowpwr_i) |=> busy); // R9

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, lowpwr_i = 1'b0;
    logic [9:0] sample_i = '0;
    logic       reg_wr_i = 1'b0, reg_rd_i = 1'b0;
    logic [1:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       busy_o, done_o;

    int n_chk = 0, n_fail = 0;
    int exp_q[$];
    bit aborted = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_seq_ctrl dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: measures each busy window and compares against the queue
    int run_len = 0;
    always @(negedge clk) begin
        if (busy_o) run_len++;
        else if (run_len > 0) begin
            if (aborted) aborted = 0;
            else if (exp_q.size() == 0) chk(0, "R2 unexpected conversion", run_len, 0);
            else begin
                int e;
                e = exp_q.pop_front();
                chk(run_len == e, "R2 busy length", run_len, e);
                chk(done_o, "R3 done on busy fall", done_o, 1);
            end
            run_len = 0;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk); reg_wr_i = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr_i = a; reg_rd_i = 1; #1 d = reg_rdata_o;
        @(negedge clk); reg_rd_i = 0;
    endtask

    task automatic start_pulse();
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && !done_o; i++) @(negedge clk);
    endtask

    task automatic convert(input int code, input logic [9:0] s);
        logic [7:0] d;
        sample_i = s;
        exp_q.push_back(39 << code);
        start_pulse();
        wait_done();
        rd(2'd0, d); chk(d == (8'h80 | 8'(code)), "R4 csr after done", d, 8'h80 | code);
        rd(2'd1, d); chk(d == {s[1:0], 6'b0}, "R3 low byte", d, {s[1:0], 6'b0});
        rd(2'd2, d); chk(d == s[9:2], "R3 high byte", d, s[9:2]);
        chk(!done_o, "R5 done cleared by high read", done_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(!busy_o && !done_o, "R1 flags", {busy_o, done_o}, 0);
        for (int a = 0; a < 3; a++) begin
            rd(2'(a), d); chk(d == 8'h00, "R1 register reset", d, 0);
        end
        // R2/R3/R4/R5 all legal codes
        for (int c = 0; c < 6; c++) begin
            wr(2'd0, 8'(c));
            rd(2'd0, d); chk(d == 8'(c), "R4 csr code readback", d, c);
            convert(c, 10'(37 * c + 515));
        end
        // R11 bits 5:3 read 0
        wr(2'd0, 8'h3A);
        rd(2'd0, d); chk(d == 8'h02, "R11 pad bits", d, 8'h02);
        // R6 restart clears done
        wr(2'd0, 8'h00);
        sample_i = 10'h155;
        exp_q.push_back(39);
        start_pulse(); wait_done();
        exp_q.push_back(39);
        start_pulse();
        chk(!done_o && busy_o, "R6 restart", {busy_o, done_o}, 2'b10);
        wait_done();
        rd(2'd2, d); chk(d == 8'h55, "R6 data after restart", d, 8'h55);
        // R8 code write during busy ignored
        exp_q.push_back(39);
        start_pulse();
        wr(2'd0, 8'h03);
        wait_done();
        rd(2'd0, d); chk(d == 8'h80, "R8 code held", d, 8'h80);
        rd(2'd2, d);
        // R9 start while busy ignored
        wr(2'd0, 8'h01);
        exp_q.push_back(78);
        start_pulse();
        repeat (20) @(negedge clk);
        start_pulse();
        wait_done();
        rd(2'd2, d);
        // R7 low-power abort keeps data
        sample_i = 10'h3FF;
        start_pulse();
        repeat (10) @(negedge clk);
        aborted = 1;
        @(negedge clk); lowpwr_i = 1;
        @(negedge clk); lowpwr_i = 0;
        chk(!busy_o && !done_o, "R7 abort flags", {busy_o, done_o}, 0);
        rd(2'd2, d); chk(d == 8'h55, "R7 data unchanged", d, 8'h55);
        // R7 low-power while a result is pending
        exp_q.push_back(78);
        start_pulse(); wait_done();
        @(negedge clk); lowpwr_i = 1;
        @(negedge clk); lowpwr_i = 0;
        chk(!done_o, "R7 done cleared", done_o, 0);
        // R10 reserved codes
        for (int c = 6; c < 8; c++) begin
            wr(2'd0, 8'(c));
            start_pulse();
            chk(!busy_o, "R10 reserved code no start", busy_o, 0);
        end
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R2 pending conversions", exp_q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule